// File: doc/BRIEF.md
# Multi-Channel Interrupt Status Controller

This block gathers event pulses from four DMA channels and a small set of global error sources into one 32-bit sticky status word. The status word raises a single interrupt line. Each channel produces five kinds of event: frame start, frame end, frame end acknowledged, line end and line end acknowledged. A channel control register decides which of these kinds that channel may record. A separate global mask register decides which error sources may record.

In the status word, the bits are grouped by event kind. Each kind takes a run of four bits, and the channel index selects the bit inside that run. The error sources follow directly after the last run. Software reads the word, then writes ones to the bits it has handled, which clears them. Zero bits in the write leave the word alone. The interrupt line stays high while any status bit is set.

The register interface is a simple write strobe with address and data. Reads are combinational from a separate read address, so software and the bench can see every stored field.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset, the status word, the error mask and all four channel control words read as zero, and `irq_o` is low.
- R2: An enabled channel event sets status bit 4*k+c, where c is the channel index and k is the kind code: frame start 0, frame end 1, frame end acknowledged 2, line end 3, line end acknowledged 4.
- R3: An enabled error pulse on `err_evt_i[e]` sets status bit 20+e, where e=0 is the overflow error and e=1..4 are the discard causes. Status bits 31..25 always read zero.
- R4: A write to address 0 clears each status bit whose data bit is one. Bits whose data bit is zero keep their value. A write to address 0 never sets a bit.
- R5: `irq_o` is high exactly when at least one status bit is set.
- R6: Channel c records an event of kind k only when bit 13+k of its own control word is set. A disabled event leaves the status word unchanged, and so does an event enabled only in another channel's control word.
- R7: Error e records only when bit e of the error mask is set. A masked error leaves the status word unchanged.
- R8: If an event and a clear of the same bit happen in the same cycle, the bit ends up set.
- R9: A status bit becomes visible on the clock edge that samples its event pulse, not before. It then stays set, with no further events, until it is cleared.
- R10: The register map is: address 0 is the status word, address 1 is the error mask (bits 4..0), and address 2+c is the control word for channel c (bits 17..13). Unused bits read as zero. Writes to addresses 6 and 7 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fs_evt_i | input | 4 | Frame start pulse, one bit per channel |
| fe_evt_i | input | 4 | Frame end pulse, one bit per channel |
| fe_ack_evt_i | input | 4 | Frame end acknowledged pulse, one bit per channel |
| le_evt_i | input | 4 | Line end pulse, one bit per channel |
| le_ack_evt_i | input | 4 | Line end acknowledged pulse, one bit per channel |
| err_evt_i | input | 5 | Error pulses: overflow at bit 0, discard causes at bits 4..1 |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 32 | Read data for `rd_addr_i` |
| irq_o | output | 1 | Interrupt request |

## Verification
Several checker properties judge a clear or a quiet cycle only when the event inputs were all low in the cycle before. They therefore assume that events and clears are separate during ordinary operation. The bench keeps to this by pulsing each event on its own cycle, with one exception: it drives an event and a clear together on purpose, once, to exercise the rule that a set wins over a clear. The error-mask properties assume the mask is stable while it is being judged. The bench therefore writes the mask one or more cycles before it pulses any error. All stimulus changes on the falling clock edge, so each pulse lasts exactly one sampling edge.

// File: rtl/isc_pkg.sv
package isc_pkg;
    localparam int NUM_TYPES    = 5;   // event kinds per channel
    localparam int NUM_ERR      = 5;   // global error sources
    localparam int CTRL_EN_LSB  = 13;  // lowest enable bit in a channel control word
    localparam int ADDR_STATUS  = 0;
    localparam int ADDR_ERRMASK = 1;
    localparam int ADDR_CH_BASE = 2;

    typedef enum logic [2:0] {
        EVT_FS     = 3'd0,
        EVT_FE     = 3'd1,
        EVT_FE_ACK = 3'd2,
        EVT_LE     = 3'd3,
        EVT_LE_ACK = 3'd4
    } evt_kind_e;
endpackage

// File: rtl/isc_sticky_bits.sv
module isc_sticky_bits #(
    parameter int W = 25
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic bit_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                bit_q <= 1'b0;
            else if (set_i[i])
                bit_q <= 1'b1;   // new event wins over a same-cycle clear
            else if (clr_i[i])
                bit_q <= 1'b0;
        end
        assign q_o[i] = bit_q;
    end
endmodule

// File: rtl/isc_err_mask.sv
module isc_err_mask #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en_i,
    input  logic [ADDR_W-1:0]            wr_addr_i,
    input  logic [DATA_W-1:0]            wr_data_i,
    output logic [isc_pkg::NUM_ERR-1:0]  mask_o
);
    import isc_pkg::*;

    logic hit;
    assign hit = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_ERRMASK));

    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_o <= '0;
        else if (hit)
            mask_o <= wr_data_i[NUM_ERR-1:0];
    end
endmodule

// File: rtl/isc_ch_ctrl.sv
module isc_ch_ctrl #(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  wr_en_i,
    input  logic [ADDR_W-1:0]                     wr_addr_i,
    input  logic [DATA_W-1:0]                     wr_data_i,
    input  logic [ADDR_W-1:0]                     rd_addr_i,
    output logic [NUM_CH*isc_pkg::NUM_TYPES-1:0]  en_o,
    output logic [DATA_W-1:0]                     rd_data_o
);
    import isc_pkg::*;

    localparam int EN_MSB = CTRL_EN_LSB + NUM_TYPES - 1;

    logic [NUM_CH-1:0][DATA_W-1:0] word;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [NUM_TYPES-1:0] en_q;
        logic                 hit;

        assign hit = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_CH_BASE + c));

        always_ff @(posedge clk) begin
            if (!rst_n)
                en_q <= '0;
            else if (hit)
                en_q <= wr_data_i[EN_MSB:CTRL_EN_LSB];
        end

        assign en_o[c*NUM_TYPES +: NUM_TYPES] = en_q;

        always_comb begin
            word[c] = '0;
            word[c][EN_MSB:CTRL_EN_LSB] = en_q;
        end
    end

    always_comb begin
        rd_data_o = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (rd_addr_i == ADDR_W'(ADDR_CH_BASE + c))
                rd_data_o = word[c];
        end
    end
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl #(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_CH-1:0]             fs_evt_i,
    input  logic [NUM_CH-1:0]             fe_evt_i,
    input  logic [NUM_CH-1:0]             fe_ack_evt_i,
    input  logic [NUM_CH-1:0]             le_evt_i,
    input  logic [NUM_CH-1:0]             le_ack_evt_i,
    input  logic [isc_pkg::NUM_ERR-1:0]   err_evt_i,
    input  logic                          wr_en_i,
    input  logic [ADDR_W-1:0]             wr_addr_i,
    input  logic [DATA_W-1:0]             wr_data_i,
    input  logic [ADDR_W-1:0]             rd_addr_i,
    output logic [DATA_W-1:0]             rd_data_o,
    output logic                          irq_o
);
    import isc_pkg::*;

    localparam int ERR_BASE = NUM_TYPES * NUM_CH;
    localparam int STAT_W   = ERR_BASE + NUM_ERR;

    logic [NUM_TYPES-1:0][NUM_CH-1:0] evt_by_kind;
    logic [NUM_CH*NUM_TYPES-1:0]      ch_en;
    logic [NUM_ERR-1:0]               err_mask;
    logic [STAT_W-1:0]                set_vec;
    logic [STAT_W-1:0]                clr_vec;
    logic [STAT_W-1:0]                stat_q;
    logic [DATA_W-1:0]                ch_rd;

    assign evt_by_kind[EVT_FS]     = fs_evt_i;
    assign evt_by_kind[EVT_FE]     = fe_evt_i;
    assign evt_by_kind[EVT_FE_ACK] = fe_ack_evt_i;
    assign evt_by_kind[EVT_LE]     = le_evt_i;
    assign evt_by_kind[EVT_LE_ACK] = le_ack_evt_i;

    isc_ch_ctrl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ch_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .rd_addr_i (rd_addr_i),
        .en_o      (ch_en),
        .rd_data_o (ch_rd)
    );

    isc_err_mask #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_err_mask (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .mask_o    (err_mask)
    );

    // status layout: kind k of channel c at k*NUM_CH + c, errors after
    for (genvar k = 0; k < NUM_TYPES; k++) begin : g_kind
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            assign set_vec[k*NUM_CH + c] = evt_by_kind[k][c] & ch_en[c*NUM_TYPES + k];
        end
    end
    for (genvar e = 0; e < NUM_ERR; e++) begin : g_err
        assign set_vec[ERR_BASE + e] = err_evt_i[e] & err_mask[e];
    end

    assign clr_vec = (wr_en_i && (wr_addr_i == ADDR_W'(ADDR_STATUS)))
                   ? wr_data_i[STAT_W-1:0] : '0;

    isc_sticky_bits #(.W(STAT_W)) u_status (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_vec),
        .clr_i (clr_vec),
        .q_o   (stat_q)
    );

    assign irq_o = |stat_q;

    always_comb begin
        rd_data_o = '0;
        if (rd_addr_i == ADDR_W'(ADDR_STATUS))
            rd_data_o[STAT_W-1:0] = stat_q;
        else if (rd_addr_i == ADDR_W'(ADDR_ERRMASK))
            rd_data_o[NUM_ERR-1:0] = err_mask;
        else
            rd_data_o = ch_rd;
    end
endmodule

// File: rtl/isc_status_chk.sv
module isc_status_chk #(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32
) (
    input logic                                       clk,
    input logic                                       rst_n,
    input logic [NUM_CH*5-1:0]                        ch_evt,
    input logic [isc_pkg::NUM_ERR-1:0]                err_evt,
    input logic [isc_pkg::NUM_ERR-1:0]                err_mask_q,
    input logic                                       wr_en,
    input logic [ADDR_W-1:0]                          wr_addr,
    input logic [DATA_W-1:0]                          wr_data,
    input logic [isc_pkg::NUM_TYPES*NUM_CH+isc_pkg::NUM_ERR-1:0] stat_q,
    input logic                                       irq_o
);
    import isc_pkg::*;

    localparam int ERR_BASE = NUM_TYPES * NUM_CH;
    localparam int STAT_W   = ERR_BASE + NUM_ERR;

    logic              quiet;
    logic [STAT_W-1:0] clr_now;
    logic [NUM_ERR-1:0] err_live;

    assign quiet    = (ch_evt == '0) && (err_evt == '0);
    assign clr_now  = (wr_en && wr_addr == ADDR_W'(ADDR_STATUS)) ? wr_data[STAT_W-1:0] : '0;
    assign err_live = err_evt & err_mask_q;

    // R5
    a_r5_irq_follows_status: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (stat_q != '0));

    // R4
    a_r4_clear_takes_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && clr_now != '0) |=> ((stat_q & $past(clr_now)) == '0));

    // R6
    a_r6_quiet_sets_nothing: assert property (@(posedge clk) disable iff (!rst_n)
        quiet |=> ((stat_q & ~$past(stat_q)) == '0));

    // R9
    a_r9_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(stat_q) & ~$past(clr_now)) & ~stat_q) == '0));

    // R7
    a_r7_masked_error_silent: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((stat_q[STAT_W-1:ERR_BASE] & ~$past(stat_q[STAT_W-1:ERR_BASE]))
                   & ~$past(err_live)) == '0));

    // R8
    a_r8_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (err_live != '0) |=> ((stat_q[STAT_W-1:ERR_BASE] & $past(err_live)) == $past(err_live)));
endmodule

bind irq_status_ctrl isc_status_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ch_evt     ({le_ack_evt_i, le_evt_i, fe_ack_evt_i, fe_evt_i, fs_evt_i}),
    .err_evt    (err_evt_i),
    .err_mask_q (err_mask),
    .wr_en      (wr_en_i),
    .wr_addr    (wr_addr_i),
    .wr_data    (wr_data_i),
    .stat_q     (stat_q),
    .irq_o      (irq_o)
);

// File: tb/irq_status_ctrl_test.sv
module irq_status_ctrl_test;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  fs = '0, fe = '0, fa = '0, le = '0, la = '0;
    logic [4:0]  err = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #(CLK_P/2) clk = ~clk;

    irq_status_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .fs_evt_i(fs), .fe_evt_i(fe), .fe_ack_evt_i(fa), .le_evt_i(le), .le_ack_evt_i(la),
        .err_evt_i(err), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq)
    );

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string what);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", what, got, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string what);
        rd_addr = a;
        #1;
        chk(rd_data, exp, what);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_evt(input int k, input int c);
        case (k)
            0: fs[c] = 1'b1;
            1: fe[c] = 1'b1;
            2: fa[c] = 1'b1;
            3: la[c] = 1'b0;
            default: ;
        endcase
        if (k == 3) le[c] = 1'b1;
        if (k == 4) la[c] = 1'b1;
    endtask

    task automatic quiet_all();
        fs = '0; fe = '0; fa = '0; le = '0; la = '0; err = '0;
    endtask

    task automatic pulse(input int k, input int c);
        @(negedge clk);
        set_evt(k, c);
        @(negedge clk);
        quiet_all();
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired got=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 6; a++) rd(3'(a), 32'h0, "R1 reset register");
        chk({31'd0, irq}, 32'h0, "R1 irq low after reset");

        // R2 / R6 / R5 / R4 sweep over channel, kind and enable
        for (int c = 0; c < 4; c++) begin
            for (int k = 0; k < 5; k++) begin
                for (int en = 0; en < 2; en++) begin
                    logic [31:0] ctl;
                    logic [31:0] exp;
                    ctl = en ? (32'h1 << (13 + k)) : (32'h0003_E000 & ~(32'h1 << (13 + k)));
                    exp = en ? (32'h1 << (4 * k + c)) : 32'h0;
                    wr(3'(2 + c), ctl);
                    pulse(k, c);
                    rd(3'd0, exp, en ? "R2 enabled event bit" : "R6 disabled event ignored");
                    chk({31'd0, irq}, {31'd0, en[0]}, "R5 irq vs status");
                    wr(3'd0, 32'hFFFF_FFFF);
                    rd(3'd0, 32'h0, "R4 clear all");
                    chk({31'd0, irq}, 32'h0, "R5 irq drops");
                end
            end
            wr(3'(2 + c), 32'h0);
        end

        // R6 another channel's enable does not record
        wr(3'd2, 32'h0003_E000);
        for (int k = 0; k < 5; k++) pulse(k, 1);
        rd(3'd0, 32'h0, "R6 foreign channel enable");
        wr(3'd2, 32'h0);

        // R3 / R7 error sweep
        for (int e = 0; e < 5; e++) begin
            for (int m = 0; m < 2; m++) begin
                wr(3'd1, m ? (32'h1 << e) : (32'h1F & ~(32'h1 << e)));
                @(negedge clk);
                err[e] = 1'b1;
                @(negedge clk);
                quiet_all();
                rd(3'd0, m ? (32'h1 << (20 + e)) : 32'h0, m ? "R3 error bit" : "R7 masked error");
                wr(3'd0, 32'hFFFF_FFFF);
            end
        end

        // R3 all sources at once, upper bits zero
        for (int c = 0; c < 4; c++) wr(3'(2 + c), 32'hFFFF_FFFF);
        wr(3'd1, 32'hFFFF_FFFF);
        @(negedge clk);
        fs = '1; fe = '1; fa = '1; le = '1; la = '1; err = '1;
        rd(3'd0, 32'h0, "R9 not visible before edge");
        @(negedge clk);
        quiet_all();
        rd(3'd0, 32'h01FF_FFFF, "R3 all bits set, top zero");

        // R4 write zero keeps, partial clear
        wr(3'd0, 32'h0);
        rd(3'd0, 32'h01FF_FFFF, "R4 write zero keeps");
        wr(3'd0, 32'h00F0_F0F0);
        rd(3'd0, 32'h010F_0F0F, "R4 partial clear");

        // R9 hold without events
        repeat (7) @(negedge clk);
        rd(3'd0, 32'h010F_0F0F, "R9 sticky hold");

        // R8 set and clear same cycle
        wr(3'd0, 32'hFFFF_FFFF);
        @(negedge clk);
        fs[2] = 1'b1;
        wr_en = 1'b1; wr_addr = 3'd0; wr_data = 32'hFFFF_FFFF;
        @(negedge clk);
        wr_en = 1'b0;
        quiet_all();
        rd(3'd0, 32'h0000_0004, "R8 set wins over clear");
        wr(3'd0, 32'hFFFF_FFFF);

        // R10 readback and unmapped writes
        rd(3'd5, 32'h0003_E000, "R10 control readback");
        rd(3'd1, 32'h0000_001F, "R10 mask readback");
        wr(3'd3, 32'h0000_4000);
        wr(3'd1, 32'h0000_0005);
        wr(3'd6, 32'h0000_0000);
        wr(3'd7, 32'h0000_0000);
        rd(3'd3, 32'h0000_4000, "R10 unmapped write ch1");
        rd(3'd1, 32'h0000_0005, "R10 unmapped write mask");
        rd(3'd0, 32'h0, "R10 unmapped write status");
        rd(3'd6, 32'h0, "R10 unmapped read");

        // R4 write ones never sets
        wr(3'd0, 32'hFFFF_FFFF);
        rd(3'd0, 32'h0, "R4 clear never sets");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule